// File: doc/BRIEF.md
# Precomputed Magnitude Comparator

This block decides whether an unsigned operand `in_a` is strictly greater than a second unsigned operand `in_b`, both `WIDTH` bits wide, and delivers the one-bit answer on a registered output. It saves switching power by precomputation. A one-bit comparison of the two top bits is made as each pair is accepted. When the top bits differ, they alone settle the answer: the registers that hold the lower `WIDTH-1` bits are not loaded, so the wide comparator behind them sees no new values. Only when the top bits are equal do those registers load and feed the narrower comparator.

Operands enter through a valid/ready stream and results leave through a second valid/ready stream. A pair is accepted on a rising edge where `in_valid` and `in_ready` are both high. A result is consumed on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the result is held unchanged. The two internal stages stall behind it, and `in_ready` drops once both are full. The strobe `lo_load` shows when the lower-bit registers load, so that the power saving can be observed from outside. Reset is synchronous and active high.

Top module: `prec_gt_cmp`

## Requirements
- R1: While `rst` is high at a clock edge, the block empties. After that edge, `out_valid` and `lo_load` are 0 and `in_ready` is 1.
- R2: Each accepted pair yields `out_gt` = 1 when `in_a > in_b` as unsigned numbers, and 0 otherwise. This includes equal operands, all-zeros and all-ones.
- R3: When a pair is accepted and bit `WIDTH-1` of `in_a` differs from bit `WIDTH-1` of `in_b`, `lo_load` stays 0 in that cycle. The result equals bit `WIDTH-1` of `in_a`.
- R4: `lo_load` is 1 exactly in the cycles in which a pair is accepted with equal top bits. It is never 1 in any other cycle.
- R5: A pair accepted at clock edge k into an empty block with `out_ready` high gives `out_valid` = 1 after edge k+1 and not before.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_gt` stays unchanged at the next edge.
- R7: Results leave in acceptance order, none lost or repeated. `in_ready` is 0 only while `out_valid` is 1 and `out_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can take a pair this cycle |
| in_a | input | WIDTH | First operand, unsigned |
| in_b | input | WIDTH | Second operand, unsigned |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_gt | output | 1 | 1 when the first operand was greater |
| lo_load | output | 1 | Lower-bit operand registers load this cycle |

## Verification
The hardest situation to reach is a full stall in which a result with differing top bits sits in the middle stage. In that case the lower registers still hold an older, unrelated pair. A wrong selection would then report a stale comparison, yet it would still look plausible. The stimulus produces this by mixing long runs of low `out_ready` with pairs whose top bits are forced equal or different at random. It also feeds near-equal operands that differ only in the lowest bits. Every accepted pair is queued with its independently computed answer, and every consumed result is compared in order.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef struct packed {
    logic a;
    logic b;
  } msb_pair_t;

  function automatic logic msb_decides(msb_pair_t p);
    return p.a ^ p.b;
  endfunction
endpackage

// File: rtl/pc_msb_unit.sv
module pc_msb_unit
  import pc_pkg::*;
(
  input  msb_pair_t pair,
  output logic      bits_eq,
  output logic      bit_gt
);
  always_comb begin
    bits_eq = ~msb_decides(pair);
    bit_gt  = pair.a & ~pair.b;
  end
endmodule

// File: rtl/pc_gated_regs.sv
module pc_gated_regs #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d_a,
  input  logic [W-1:0] d_b,
  output logic [W-1:0] q_a,
  output logic [W-1:0] q_b
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_a <= '0;
      q_b <= '0;
    end else if (load) begin
      q_a <= d_a;
      q_b <= d_b;
    end
  end
endmodule

// File: rtl/pc_lower_cmp.sv
module pc_lower_cmp #(
  parameter int W = 15
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         gt
);
  logic [W:0] gt_chain;
  logic [W:0] eq_chain;

  assign gt_chain[W] = 1'b0;
  assign eq_chain[W] = 1'b1;

  for (genvar i = W - 1; i >= 0; i--) begin : g_bit
    assign gt_chain[i] = gt_chain[i+1] | (eq_chain[i+1] & a[i] & ~b[i]);
    assign eq_chain[i] = eq_chain[i+1] & ~(a[i] ^ b[i]);
  end

  assign gt = gt_chain[0];
endmodule

// File: rtl/prec_gt_cmp.sv
module prec_gt_cmp
  import pc_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_gt,
  output logic             lo_load
);
  localparam int LW = WIDTH - 1;

  msb_pair_t   in_msb;
  msb_pair_t   st_msb;
  logic        in_eq;
  logic        in_gt_unused;
  logic        st_eq;
  logic        st_gt;
  logic        st_valid;
  logic        out_v_q;
  logic        out_gt_q;
  logic        adv_out;
  logic        in_fire;
  logic [LW-1:0] lo_a_q;
  logic [LW-1:0] lo_b_q;
  logic        lo_gt;
  logic        result_d;

  assign in_msb.a = in_a[WIDTH-1];
  assign in_msb.b = in_b[WIDTH-1];

  pc_msb_unit u_pre (.pair(in_msb), .bits_eq(in_eq), .bit_gt(in_gt_unused));
  pc_msb_unit u_top (.pair(st_msb), .bits_eq(st_eq), .bit_gt(st_gt));

  assign adv_out  = ~out_v_q | out_ready;
  assign in_ready = ~st_valid | adv_out;
  assign in_fire  = in_valid & in_ready;
  assign lo_load  = in_fire & in_eq;

  pc_gated_regs #(.W(LW)) u_lo (
    .clk  (clk),
    .rst  (rst),
    .load (lo_load),
    .d_a  (in_a[LW-1:0]),
    .d_b  (in_b[LW-1:0]),
    .q_a  (lo_a_q),
    .q_b  (lo_b_q)
  );

  pc_lower_cmp #(.W(LW)) u_cmp (.a(lo_a_q), .b(lo_b_q), .gt(lo_gt));

  assign result_d = st_eq ? lo_gt : st_gt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_valid <= 1'b0;
      st_msb   <= '0;
    end else if (in_fire) begin
      st_valid <= 1'b1;
      st_msb   <= in_msb;
    end else if (adv_out) begin
      st_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_v_q  <= 1'b0;
      out_gt_q <= 1'b0;
    end else if (adv_out) begin
      out_v_q <= st_valid;
      if (st_valid) out_gt_q <= result_d;
    end
  end

  assign out_valid = out_v_q;
  assign out_gt    = out_gt_q;
endmodule

// File: rtl/pc_checker.sv
module pc_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] in_a,
  input logic [WIDTH-1:0] in_b,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_gt,
  input logic             lo_load
);
  logic acc;
  logic same_top;
  assign acc      = in_valid & in_ready;
  assign same_top = in_a[WIDTH-1] == in_b[WIDTH-1];

  AST_RESET_EMPTY: assert property (@(posedge clk) rst |=> !out_valid); // R1
  AST_SKIP_LOWER: assert property (@(posedge clk) disable iff (rst)
    (acc && !same_top) |-> !lo_load); // R3
  AST_LOAD_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    lo_load |-> (acc && same_top)); // R4
  AST_RESULT_LATE: assert property (@(posedge clk) disable iff (rst)
    acc |=> ##1 out_valid); // R5
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_gt))); // R6
  AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (out_valid && !out_ready)); // R7
endmodule

bind prec_gt_cmp pc_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
  .out_gt(out_gt), .lo_load(lo_load)
);

// File: tb/prec_gt_cmp_test.sv
module prec_gt_cmp_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid, in_ready, out_valid, out_ready, out_gt, lo_load;
  logic [W-1:0] in_a, in_b;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  bit  exp_q[$];
  bit  prev_blocked = 0;
  bit  prev_gt = 0;

  always #2.5 clk = ~clk;

  prec_gt_cmp #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_gt(out_gt), .lo_load(lo_load)
  );

  function automatic bit ref_gt(logic [W-1:0] a, logic [W-1:0] b);
    return a > b;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, evaluate, advance to next negedge
  task automatic cycle(bit v, logic [W-1:0] a, logic [W-1:0] b, bit rdy);
    bit fire;
    bit eqtop;
    in_valid = v; in_a = a; in_b = b; out_ready = rdy;
    #1;
    fire  = in_valid && in_ready;
    eqtop = a[W-1] == b[W-1];
    if (prev_blocked) begin
      check(out_valid == 1'b1, "R6 valid held", int'(out_valid), 1);
      check(out_gt == prev_gt, "R6 result held", int'(out_gt), int'(prev_gt));
    end
    if (!in_ready) check(out_valid && !out_ready, "R7 ready drop", int'(in_ready), 1);
    if (fire && !eqtop) check(lo_load == 1'b0, "R3 no lower load", int'(lo_load), 0);
    else check(lo_load == (fire && eqtop), "R4 load strobe", int'(lo_load), int'(fire && eqtop));
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check(0, "R7 extra result", 1, 0);
      else begin
        bit e;
        e = exp_q.pop_front();
        check(out_gt == e, "R2 compare result", int'(out_gt), int'(e));
      end
    end
    if (fire) exp_q.push_back(ref_gt(a, b));
    prev_blocked = out_valid && !out_ready;
    prev_gt      = out_gt;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 8; i++) cycle(0, '0, '0, 1);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit seed_dummy;
    rst = 1'b1; in_valid = 0; in_a = '0; in_b = '0; out_ready = 0;
    seed_dummy = bit'($urandom(32'h5EED_C0DE));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(out_valid == 0, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1, "R1 in_ready after reset", int'(in_ready), 1);
    check(lo_load == 0, "R1 lo_load after reset", int'(lo_load), 0);
    @(negedge clk);

    // R5 latency from empty
    cycle(1, 16'h8000, 16'h7FFF, 1);
    check(out_valid == 0, "R5 not yet valid", int'(out_valid), 0);
    cycle(0, '0, '0, 0);
    check(out_valid == 1, "R5 valid after second edge", int'(out_valid), 1);
    drain();

    // directed corners (R2, R3, R4)
    cycle(1, 16'h0000, 16'h0000, 1);
    cycle(1, 16'hFFFF, 16'hFFFF, 1);
    cycle(1, 16'h7FFF, 16'h8000, 1);
    cycle(1, 16'h8001, 16'h8000, 1);
    cycle(1, 16'h8000, 16'h8001, 1);
    cycle(1, 16'h0001, 16'h0000, 1);
    cycle(1, 16'hFFFE, 16'hFFFF, 1);
    drain();

    // stale lower regs: equal-top pair loads, then differing-top pair stalls
    cycle(1, 16'h0005, 16'h0003, 0);
    cycle(1, 16'h0001, 16'h8009, 0);
    cycle(1, 16'h8002, 16'h0004, 0);
    for (int i = 0; i < 4; i++) cycle(0, '0, '0, 0);
    drain();

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [W-1:0] a, b;
      int mode;
      a = W'($urandom);
      b = W'($urandom);
      mode = $urandom_range(0, 3);
      if (mode == 0) b[W-1] = a[W-1];
      else if (mode == 1) b = a ^ W'($urandom_range(0, 3));
      else if (mode == 2) b[W-1] = ~a[W-1];
      cycle(($urandom_range(0, 9) < 7), a, b, ($urandom_range(0, 9) < 6));
    end
    drain();
    check(exp_q.size() == 0, "R7 all results delivered", exp_q.size(), 0);

    // reset mid-stream empties the block (R1)
    cycle(1, 16'h1234, 16'h0042, 0);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0; in_valid = 0;
    #1;
    check(out_valid == 0, "R1 out_valid after mid reset", int'(out_valid), 0);
    check(in_ready == 1, "R1 in_ready after mid reset", int'(in_ready), 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule